// File: doc/BRIEF.md
# Lost-Clock Sustain Audio Fader

This block keeps a locally powered node quiet and orderly when it stops hearing the bus. A lock-loss indication tells it that the recovered clock can no longer be trusted. From then on it runs on the free-running local clock and counts frame syncs for a fixed number of periods. During those periods it scales both outgoing serial audio channels from their present level down to silence. When the count ends it issues a reset request, and the node goes back to its power-up state. It does not resume normal operation.

While the node is healthy, samples pass through with no added latency. The fade gain counts down by one step per frame sync. Each output sample is the input multiplied by the gain and divided by the period count, rounded toward minus infinity. An optional status output marks the sustain episode for local software or a pin.

Top module: `sustain_fader`

## Requirements
- R1: Reset state: after synchronous active-low reset the block is in power-up. `samp_out` is all zeros, and `sustain_flag` and `reset_req` are low. It moves to normal operation at the first clock edge where `lock_lost` is low. While in power-up the outputs stay zero.
- R2: In normal operation `samp_out` equals `samp_in` in the same cycle, with no register in the data path.
- R3: A clock edge that finds normal operation with `lock_lost` high enters sustain with a gain of SUSTAIN_PERIODS (1024 by default). A `frame_sync` on that same edge is not counted. In the first sustain cycle the output therefore equals the input.
- R4: `sustain_flag` rises on sustain entry only if `status_en` is high on the entry edge. It then holds through the whole episode and clears on the return to power-up.
- R5: In sustain, every clock edge with `frame_sync` high lowers the gain by one. Each channel of `samp_out` is a W-bit two's-complement field, with channel 0 in the low bits. Each channel equals floor(input × gain / SUSTAIN_PERIODS).
- R6: Once sustain is entered, the value of `lock_lost` has no effect. The block stays in sustain until the full count of syncs is done.
- R7: The edge carrying the SUSTAIN_PERIODS-th sync of an episode leads to one cycle with `reset_req` high and `samp_out` zero. The block then returns to power-up on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_lost | input | 1 | High while the bus clock cannot be recovered |
| frame_sync | input | 1 | One-cycle strobe per audio frame |
| status_en | input | 1 | Enables the sustain status output |
| samp_in | input | NCH*SAMPLE_W | Outgoing samples, channel 0 in low bits |
| samp_out | output | NCH*SAMPLE_W | Faded samples to the serial transmitter |
| sustain_flag | output | 1 | Sustain episode status |
| reset_req | output | 1 | One-cycle request to reset the node |

## Verification
Two events can land on the same edge: the entry into sustain and a frame sync. The sync must not be counted, so the first sustain cycle passes samples at full gain. A second pair can also coincide: the last sync of an episode and lock coming back. That pair must still end in a reset request. The bench raises frame sync at random on half of all cycles and toggles lock loss freely during sustain, so both pairings occur many times. An independent per-cycle model of state and gain judges every output. Extreme sample values are mixed in to test the signed floor rounding.

// File: rtl/sfade_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the sustain fader.
package sfade_pkg;
    typedef enum logic [1:0] {
        ST_POWERUP   = 2'd0,
        ST_NORMAL    = 2'd1,
        ST_SUSTAIN   = 2'd2,
        ST_RESET_REQ = 2'd3
    } sfade_state_e;
endpackage

// File: rtl/sfade_gain_cnt.sv
`timescale 1ns/1ps
// Module: sfade_gain_cnt
// Down-counter holding the fade gain. A load sets it to full scale and a step lowers it by one.
// Assumes load and step are never both high; load wins if they are.
module sfade_gain_cnt #(
    parameter int PERIODS = 1024,
    parameter int GAIN_W  = $clog2(PERIODS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [GAIN_W-1:0] gain,
    output logic              last
);
    // Purpose: hold, load or decrement the gain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain <= '0;
        else if (load)
            gain <= GAIN_W'(PERIODS);
        else if (step)
            gain <= gain - GAIN_W'(1);
    end

    // Purpose: flag that the next step brings the gain to zero.
    assign last = (gain == GAIN_W'(1));
endmodule

// File: rtl/sfade_ctrl.sv
`timescale 1ns/1ps
// Module: sfade_ctrl
// Episode state machine: power-up, normal, sustain and reset request. Also drives the status flag.
// Assumes gain_last comes from the gain counter and is valid in every cycle.
module sfade_ctrl
    import sfade_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_lost,
    input  logic         frame_sync,
    input  logic         status_en,
    input  logic         gain_last,
    output sfade_state_e state,
    output logic         gain_load,
    output logic         gain_step,
    output logic         sustain_flag,
    output logic         reset_req
);
    sfade_state_e state_nx;
    logic         enter_sus;

    // Purpose: detect the edge that starts a sustain episode.
    assign enter_sus = (state == ST_NORMAL) && lock_lost;
    assign gain_load = enter_sus;
    assign gain_step = (state == ST_SUSTAIN) && frame_sync;
    assign reset_req = (state == ST_RESET_REQ);

    // Purpose: next-state decode; lock_lost is not looked at inside sustain.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWERUP:   if (!lock_lost) state_nx = ST_NORMAL;
            ST_NORMAL:    if (lock_lost) state_nx = ST_SUSTAIN;
            ST_SUSTAIN:   if (frame_sync && gain_last) state_nx = ST_RESET_REQ;
            ST_RESET_REQ: state_nx = ST_POWERUP;
            default:      state_nx = ST_POWERUP;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_POWERUP;
        else
            state <= state_nx;
    end

    // Purpose: capture the status enable on entry and clear the flag on the way back to power-up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sustain_flag <= 1'b0;
        else if (enter_sus)
            sustain_flag <= status_en;
        else if (state == ST_RESET_REQ)
            sustain_flag <= 1'b0;
    end
endmodule

// File: rtl/sfade_scaler.sv
`timescale 1ns/1ps
// Module: sfade_scaler
// Combinational per-channel gain stage: pass, scale by gain/2^SHIFT with floor rounding, or mute.
// Assumes the sample is two's complement and gain <= 2^SHIFT, so the result fits in SAMPLE_W bits.
module sfade_scaler #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 11,
    parameter int SHIFT    = 10
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W-1:0]   gain,
    input  logic                pass_en,
    input  logic                scale_en,
    output logic [SAMPLE_W-1:0] result
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    logic signed [PROD_W-1:0] prod;

    // Purpose: signed product of the sample and the non-negative gain.
    assign prod = PROD_W'($signed(sample)) * PROD_W'($signed({1'b0, gain}));

    // Purpose: choose pass-through, scaled or muted output.
    always_comb begin
        if (pass_en)
            result = sample;
        else if (scale_en)
            result = SAMPLE_W'(prod >>> SHIFT);
        else
            result = '0;
    end
endmodule

// File: rtl/sustain_fader.sv
`timescale 1ns/1ps
// Module: sustain_fader (top)
// Lost-clock sustain fader: on lock loss, fades NCH channels to silence over SUSTAIN_PERIODS frame syncs, then requests a node reset.
// Assumes SUSTAIN_PERIODS is a power of two, frame_sync is a one-cycle strobe, and clk keeps running after lock loss.
module sustain_fader
    import sfade_pkg::*;
#(
    parameter int SAMPLE_W        = 24,
    parameter int NCH             = 2,
    parameter int SUSTAIN_PERIODS = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_lost,
    input  logic                    frame_sync,
    input  logic                    status_en,
    input  logic [NCH*SAMPLE_W-1:0] samp_in,
    output logic [NCH*SAMPLE_W-1:0] samp_out,
    output logic                    sustain_flag,
    output logic                    reset_req
);
    localparam int SHIFT  = $clog2(SUSTAIN_PERIODS);
    localparam int GAIN_W = SHIFT + 1;

    sfade_state_e      state_w;
    logic [GAIN_W-1:0] gain_w;
    logic              load_w;
    logic              step_w;
    logic              last_w;
    logic              pass_w;
    logic              scale_w;

    sfade_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_lost    (lock_lost),
        .frame_sync   (frame_sync),
        .status_en    (status_en),
        .gain_last    (last_w),
        .state        (state_w),
        .gain_load    (load_w),
        .gain_step    (step_w),
        .sustain_flag (sustain_flag),
        .reset_req    (reset_req)
    );

    sfade_gain_cnt #(
        .PERIODS (SUSTAIN_PERIODS),
        .GAIN_W  (GAIN_W)
    ) gain_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .step  (step_w),
        .gain  (gain_w),
        .last  (last_w)
    );

    // Purpose: data-path mode from the episode state.
    assign pass_w  = (state_w == ST_NORMAL);
    assign scale_w = (state_w == ST_SUSTAIN);

    // Purpose: one gain stage per transmit channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sfade_scaler #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_W   (GAIN_W),
            .SHIFT    (SHIFT)
        ) scl_i (
            .sample   (samp_in[c*SAMPLE_W +: SAMPLE_W]),
            .gain     (gain_w),
            .pass_en  (pass_w),
            .scale_en (scale_w),
            .result   (samp_out[c*SAMPLE_W +: SAMPLE_W])
        );
    end
endmodule

// File: rtl/sfade_chk.sv
`timescale 1ns/1ps
// Module: sfade_chk
// Property checker for sustain_fader, attached by bind below.
module sfade_chk
    import sfade_pkg::*;
#(
    parameter int SAMPLE_W        = 24,
    parameter int NCH             = 2,
    parameter int SUSTAIN_PERIODS = 1024,
    parameter int GAIN_W          = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lock_lost,
    input logic                    frame_sync,
    input logic                    status_en,
    input sfade_state_e            state,
    input logic [GAIN_W-1:0]       gain,
    input logic [NCH*SAMPLE_W-1:0] samp_in,
    input logic [NCH*SAMPLE_W-1:0] samp_out,
    input logic                    sustain_flag,
    input logic                    reset_req
);
    // R2: normal operation passes data in the same cycle
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL) |-> (samp_out == samp_in));

    // R3: entry loads the full gain, and a coincident sync is not counted
    a_r3_entry_full_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && lock_lost) |=> (state == ST_SUSTAIN && gain == GAIN_W'(SUSTAIN_PERIODS)));

    // R4: flag stays low when the status output is disabled on entry
    a_r4_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && lock_lost && !status_en) |=> !sustain_flag);

    // R4: flag is clear in power-up
    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWERUP) |-> !sustain_flag);

    // R5: each sync in sustain lowers the gain by one
    a_r5_gain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSTAIN && frame_sync) |=> (gain == $past(gain) - GAIN_W'(1)));

    // R6: sustain is left only through the final sync
    a_r6_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSTAIN && !(frame_sync && gain == GAIN_W'(1))) |=> (state == ST_SUSTAIN));

    // R7: reset request is a single pulse followed by power-up
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (!reset_req && state == ST_POWERUP));

    // R7: output is silent while the reset is requested
    a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (samp_out == '0));
endmodule

bind sustain_fader sfade_chk #(
    .SAMPLE_W        (SAMPLE_W),
    .NCH             (NCH),
    .SUSTAIN_PERIODS (SUSTAIN_PERIODS),
    .GAIN_W          (GAIN_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_lost    (lock_lost),
    .frame_sync   (frame_sync),
    .status_en    (status_en),
    .state        (state_w),
    .gain         (gain_w),
    .samp_in      (samp_in),
    .samp_out     (samp_out),
    .sustain_flag (sustain_flag),
    .reset_req    (reset_req)
);

// File: tb/sustain_fader_tb_top.sv
`timescale 1ns/1ps
// Bench: random stimulus from a fixed seed plus extreme samples, judged against a cycle model.
module sustain_fader_tb_top;
    localparam int SW    = 24;
    localparam int NCH   = 2;
    localparam int PER   = 1024;
    localparam int SH    = $clog2(PER);
    localparam int EPIS  = 6;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                lock_lost;
    logic                frame_sync;
    logic                status_en;
    logic [NCH*SW-1:0]   samp_in;
    logic [NCH*SW-1:0]   samp_out;
    logic                sustain_flag;
    logic                reset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model: 0 power-up, 1 normal, 2 sustain, 3 reset request
    int m_state;
    int m_gain;
    bit m_flag;

    always #5 clk = ~clk;

    sustain_fader #(.SAMPLE_W(SW), .NCH(NCH), .SUSTAIN_PERIODS(PER)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_lost    (lock_lost),
        .frame_sync   (frame_sync),
        .status_en    (status_en),
        .samp_in      (samp_in),
        .samp_out     (samp_out),
        .sustain_flag (sustain_flag),
        .reset_req    (reset_req)
    );

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] scale_ch(logic [SW-1:0] x, int g);
        longint v;
        v = longint'($signed(x));
        v = (v * longint'(g)) >>> SH;
        return SW'(v);
    endfunction

    function automatic logic [NCH*SW-1:0] exp_out(int st, int g, logic [NCH*SW-1:0] x);
        logic [NCH*SW-1:0] r;
        r = '0;
        for (int c = 0; c < NCH; c++) begin
            if (st == 1) r[c*SW +: SW] = x[c*SW +: SW];
            else if (st == 2) r[c*SW +: SW] = scale_ch(x[c*SW +: SW], g);
        end
        return r;
    endfunction

    function automatic logic [SW-1:0] pick_sample();
        int k;
        k = $urandom_range(0, 7);
        if (k == 0) return {1'b1, {(SW-1){1'b0}}};
        if (k == 1) return {1'b0, {(SW-1){1'b1}}};
        if (k == 2) return {SW{1'b1}};
        return SW'($urandom);
    endfunction

    initial begin
        #(2_000_000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int episodes;
        int cyc;
        logic [NCH*SW-1:0] e;
        string tag;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        lock_lost = 1'b1;
        frame_sync = 1'b0;
        status_en = 1'b1;
        samp_in = {NCH{pick_sample()}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        samp_in = {{1'b0, {(SW-1){1'b1}}}, {1'b0, {(SW-1){1'b1}}}};
        #1;
        check(samp_out == '0, "R1", "reset samp_out", 64'(samp_out), 64'd0);
        check(!sustain_flag, "R1", "reset sustain_flag", 64'(sustain_flag), 64'd0);
        check(!reset_req, "R1", "reset reset_req", 64'(reset_req), 64'd0);
        rst_n = 1'b1;
        m_state = 0;
        m_gain = 0;
        m_flag = 1'b0;
        episodes = 0;
        cyc = 0;
        @(posedge clk);
        while (episodes < EPIS && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            case (m_state)
                0: lock_lost = ($urandom_range(0, 3) == 0);
                1: lock_lost = ($urandom_range(0, 199) == 0);
                default: lock_lost = $urandom_range(0, 1) == 1;
            endcase
            frame_sync = $urandom_range(0, 1) == 1;
            status_en = $urandom_range(0, 1) == 1;
            for (int c = 0; c < NCH; c++) samp_in[c*SW +: SW] = pick_sample();
            #1;
            e = exp_out(m_state, m_gain, samp_in);
            case (m_state)
                0: tag = "R1";
                1: tag = "R2";
                2: tag = (m_gain == PER) ? "R3" : (!lock_lost ? "R6" : "R5");
                default: tag = "R7";
            endcase
            check(samp_out == e, tag, "samp_out", 64'(samp_out), 64'(e));
            check(sustain_flag == m_flag, "R4", "sustain_flag", 64'(sustain_flag), 64'(m_flag));
            check(reset_req == (m_state == 3), "R7", "reset_req", 64'(reset_req), 64'(m_state == 3));
            @(posedge clk);
            case (m_state)
                0: if (!lock_lost) m_state = 1;
                1: if (lock_lost) begin m_state = 2; m_gain = PER; m_flag = status_en; end
                2: if (frame_sync) begin
                       m_gain = m_gain - 1;
                       if (m_gain == 0) m_state = 3;
                   end
                default: begin m_state = 0; m_flag = 1'b0; episodes++; end
            endcase
        end
        check(episodes == EPIS, "R7", "completed episodes", 64'(episodes), 64'(EPIS));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule